// File: doc/BRIEF.md
# Delegated Counter Indirect Access Unit

This unit sits behind the supervisor's indirect CSR window. When supervisor software puts a select value in the window that names a performance counter, it then reaches that counter through one of six numbered alias data registers. The unit decides whether the access is allowed. If it is, the unit reads or writes the counter word, or the event-selector/configuration word, that the alias names. If it is not, the unit raises an illegal-instruction or a virtual-instruction exception. It holds the count and configuration registers for counters 0 and 2 through 31. Counter 1 is the real-time timer slot and is never reachable through this window.

A request is presented for one cycle with `req_valid`. The registered response appears on the next cycle with `rsp_valid`. A write response returns the value held before the write. Any exception suppresses the write and forces the read data to zero.

The machine level controls access through three things: a global delegation enable bit, a per-counter enable mask, and a state-enable gate that is checked before anything else. Bit 62 of every event-selector/configuration register is hidden from this path.

Top module: `dlg_ctr_access`

## Requirements
- R1: Select values 0x40 through 0x5F address counter (select − 0x40). A select value outside that range raises no exception, returns zero data and changes no state.
- R2: Alias 1 is the counter and alias 2 is the event/configuration word. With `xlen64`=1 these are full 64-bit views. With `xlen64`=0 they are the low 32 bits, alias 4 is the counter's high 32 bits and alias 5 is the configuration's high 32 bits. A 32-bit view is zero-extended on read and replaces only its own half on write. A legal access responds with the value held before the access.
- R3: An access in range raises illegal instruction when `dlg_en`=0, or when `ctr_en` bit i is 0 for the selected counter i.
- R4: Aliases 0, 3, 6 and 7 always raise illegal instruction in range. Aliases 4 and 5 raise illegal instruction when `xlen64`=1.
- R5: Select value 0x41 raises illegal instruction for every alias.
- R6: `feat` bit 0 means the base counters exist, bit 1 means the hardware counters exist, bit 2 means the event high-word filter exists, and bit 3 means the base-counter configuration exists. Alias 1/4 of counters 0 and 2 needs bit 0, and alias 2/5 of those counters needs bit 3. Counters 3–31 need bit 1 and their bit in parameter `HPM_MASK`, and their alias 5 also needs bit 2. Any missing dependency raises illegal instruction.
- R7: Bit 62 of an event/configuration register reads as 0 through the aliases. A write through an alias leaves bit 62 unchanged. In the 32-bit high view this is bit 30.
- R8: With `virt_on`=1 and `prv`=1 (S), an in-range access raises virtual instruction when `dlg_en`=1 and illegal instruction when `dlg_en`=0. With `virt_on`=1 and `prv`=0 it raises virtual instruction. With `virt_on`=0 and `prv`=0 it raises illegal instruction. `prv` encodes 0=U, 1=S, 3=M.
- R9: With `virt_on`=0 and `guest_sel`=1, an in-range access from M or S raises illegal instruction.
- R10: When `gate_open`=0, every access raises illegal instruction and no other rule applies.
- R11: An access that raises an exception writes nothing and returns zero read data. At most one exception flag is set.
- R12: The response (`rsp_valid` and its data and flags) appears exactly one cycle after `req_valid`. After reset all registers are zero and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| prv | input | 2 | Privilege mode (0 U, 1 S, 3 M) |
| virt_on | input | 1 | Virtualization mode active |
| guest_sel | input | 1 | Access targets the guest select/alias set |
| sel | input | 9 | Indirect select value |
| alias_num | input | 3 | Alias data register number (1–6) |
| wdata | input | 64 | Write data |
| xlen64 | input | 1 | 1 = 64-bit register width |
| dlg_en | input | 1 | Global delegation enable |
| ctr_en | input | 32 | Per-counter enable mask |
| gate_open | input | 1 | State-enable gate for the indirect window |
| feat | input | 4 | Implemented-feature flags (see R6) |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 64 | Read data |
| rsp_ill | output | 1 | Illegal-instruction exception |
| rsp_virt | output | 1 | Virtual-instruction exception |

## Verification
Each response is checked against an independent model of the register file and the access rules. The bench stresses the priority corners:
- A closed gate while in VS-mode must give illegal, not virtual. A design that checks the gate late reports the wrong exception.
- Select 0x41 with every enable set must still raise illegal. A design without the special case reads counter 1.
- The 32-bit half-writes and the all-ones configuration writes must leave the other half, and bit 62, unchanged. A design that gets the merge wrong corrupts them.
- A refused write followed by a read must return the old value. A design that writes before deciding legality returns the new one.
- The 0x40/0x5F edges and the non-existent counter 9 must decode correctly. An off-by-one decoder, or one that ignores the existence mask, gets these wrong.

// File: rtl/dca_pkg.sv
package dca_pkg;
    localparam int XW       = 64;
    localparam int HW       = XW / 2;
    localparam int NCTR     = 32;
    localparam int IDX_W    = $clog2(NCTR);
    localparam int SEL_W    = 9;
    localparam int HIDE_BIT = 62;
    localparam int NFEAT    = 4;

    localparam logic [SEL_W-1:0] SEL_BASE  = SEL_W'(9'h040);
    localparam logic [SEL_W-1:0] SEL_TIMER = SEL_W'(9'h041);
    localparam logic [XW-1:0]    HIDE_MASK = XW'(1) << HIDE_BIT;

    // feature flag positions
    localparam int FT_BASE = 0;
    localparam int FT_HPM  = 1;
    localparam int FT_OVF  = 2;
    localparam int FT_CFG  = 3;

    typedef enum logic [1:0] {
        PRV_U = 2'd0,
        PRV_S = 2'd1,
        PRV_H = 2'd2,
        PRV_M = 2'd3
    } prv_e;

    typedef enum logic [2:0] {
        AL_NONE = 3'd0,
        AL_CNT  = 3'd1,
        AL_CFG  = 3'd2,
        AL_RSV3 = 3'd3,
        AL_CNTH = 3'd4,
        AL_CFGH = 3'd5,
        AL_RSV6 = 3'd6,
        AL_RSV7 = 3'd7
    } alias_e;

    typedef struct packed {
        logic              legal;
        logic              ill;
        logic              virt;
        logic [IDX_W-1:0]  idx;
        alias_e            kind;
        logic              wide;
    } dec_t;

    function automatic logic ctr_exists(input logic [IDX_W-1:0] i,
                                        input logic [NCTR-1:0]  mask);
        return (i == IDX_W'(0)) || (i == IDX_W'(2)) ||
               ((i >= IDX_W'(3)) && mask[i]);
    endfunction

    function automatic logic is_count_alias(input alias_e k);
        return (k == AL_CNT) || (k == AL_CNTH);
    endfunction

    function automatic logic is_cfg_alias(input alias_e k);
        return (k == AL_CFG) || (k == AL_CFGH);
    endfunction
endpackage

// File: rtl/dca_decode.sv
module dca_decode
    import dca_pkg::*;
#(
    parameter logic [NCTR-1:0] HPM_MASK = 32'h8000_00F8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        prv,
    input  logic              virt_on,
    input  logic              guest_sel,
    input  logic [SEL_W-1:0]  sel,
    input  logic [2:0]        alias_num,
    input  logic              xlen64,
    input  logic              dlg_en,
    input  logic [NCTR-1:0]   ctr_en,
    input  logic              gate_open,
    input  logic [NFEAT-1:0]  feat,
    output dec_t              dec
);
    logic             in_range;
    logic [SEL_W-1:0] off;
    logic [IDX_W-1:0] idx;
    alias_e           kind;
    prv_e             mode;
    logic             alias_ok;
    logic             width_ok;
    logic             feat_ok;
    logic             ill;
    logic             virt;

    assign off      = sel - SEL_BASE;
    assign in_range = (sel >= SEL_BASE) && (off < SEL_W'(NCTR));
    assign idx      = off[IDX_W-1:0];
    assign kind     = alias_e'(alias_num);
    assign mode     = prv_e'(prv);

    assign alias_ok = (kind == AL_CNT) || (kind == AL_CFG) ||
                      (kind == AL_CNTH) || (kind == AL_CFGH);
    assign width_ok = !(xlen64 && ((kind == AL_CNTH) || (kind == AL_CFGH)));

    always_comb begin
        if ((idx == IDX_W'(0)) || (idx == IDX_W'(2))) begin
            feat_ok = is_count_alias(kind) ? feat[FT_BASE] : feat[FT_CFG];
        end else begin
            feat_ok = feat[FT_HPM] && ctr_exists(idx, HPM_MASK) &&
                      ((kind != AL_CFGH) || feat[FT_OVF]);
        end
    end

    // rule chain: earlier rules win
    always_comb begin
        ill  = 1'b0;
        virt = 1'b0;
        if (!req_valid) begin
            ill = 1'b0;
        end else if (!gate_open) begin
            ill = 1'b1;
        end else if (!in_range) begin
            ill = 1'b0;
        end else if (virt_on) begin
            if (mode == PRV_U)   virt = 1'b1;
            else if (dlg_en)     virt = 1'b1;
            else                 ill  = 1'b1;
        end else if (mode == PRV_U) begin
            ill = 1'b1;
        end else if (guest_sel) begin
            ill = 1'b1;
        end else if (!dlg_en) begin
            ill = 1'b1;
        end else if (!alias_ok || !width_ok) begin
            ill = 1'b1;
        end else if (sel == SEL_TIMER) begin
            ill = 1'b1;
        end else if (!ctr_en[idx]) begin
            ill = 1'b1;
        end else if (!feat_ok) begin
            ill = 1'b1;
        end
    end

    always_comb begin
        dec.legal = req_valid && gate_open && in_range && !ill && !virt;
        dec.ill   = ill;
        dec.virt  = virt;
        dec.idx   = idx;
        dec.kind  = kind;
        dec.wide  = xlen64;
    end

    // R11: never both exception kinds at once
    p_single_exc_r11: assert property (@(posedge clk) disable iff (rst)
        !(dec.ill && dec.virt));

    // R3: a granted access had delegation and its counter enabled
    p_legal_needs_dlg_r3: assert property (@(posedge clk) disable iff (rst)
        dec.legal |-> (dlg_en && ctr_en[dec.idx]));

    // R5: timer slot is never granted
    p_timer_slot_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sel == SEL_TIMER) |-> (dec.ill || dec.virt));
endmodule

// File: rtl/dca_bank.sv
module dca_bank
    import dca_pkg::*;
#(
    parameter logic [NCTR-1:0] HPM_MASK = 32'h8000_00F8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  alias_e            kind,
    input  logic              wide,
    input  logic [XW-1:0]     wdata,
    output logic [XW-1:0]     rd_data
);
    logic [XW-1:0] cnt_v [NCTR];
    logic [XW-1:0] cfg_v [NCTR];
    logic [XW-1:0] cur_cnt;
    logic [XW-1:0] cur_cfg;
    logic [XW-1:0] nxt_cnt;
    logic [XW-1:0] nxt_cfg;
    logic [XW-1:0] view;
    logic          cnt_we;
    logic          cfg_we;

    assign cur_cnt = cnt_v[idx];
    assign cur_cfg = cfg_v[idx];
    assign cnt_we  = wr_en && is_count_alias(kind);
    assign cfg_we  = wr_en && is_cfg_alias(kind);

    // read view of the selected word, hidden bit removed
    always_comb begin
        unique case (kind)
            AL_CNT:  view = wide ? cur_cnt : {{HW{1'b0}}, cur_cnt[HW-1:0]};
            AL_CNTH: view = {{HW{1'b0}}, cur_cnt[XW-1:HW]};
            AL_CFG:  view = wide ? (cur_cfg & ~HIDE_MASK)
                                 : {{HW{1'b0}}, cur_cfg[HW-1:0]};
            AL_CFGH: view = {{HW{1'b0}}, cur_cfg[XW-1:HW] & ~HIDE_MASK[XW-1:HW]};
            default: view = '0;
        endcase
    end

    assign rd_data = rd_en ? view : '0;

    // merged write values
    always_comb begin
        nxt_cnt = cur_cnt;
        nxt_cfg = cur_cfg;
        unique case (kind)
            AL_CNT:  nxt_cnt = wide ? wdata : {cur_cnt[XW-1:HW], wdata[HW-1:0]};
            AL_CNTH: nxt_cnt = {wdata[HW-1:0], cur_cnt[HW-1:0]};
            AL_CFG:  nxt_cfg = wide ? ((wdata & ~HIDE_MASK) | (cur_cfg & HIDE_MASK))
                                    : {cur_cfg[XW-1:HW], wdata[HW-1:0]};
            AL_CFGH: nxt_cfg = ({wdata[HW-1:0], cur_cfg[HW-1:0]} & ~HIDE_MASK) |
                               (cur_cfg & HIDE_MASK);
            default: begin
                nxt_cnt = cur_cnt;
                nxt_cfg = cur_cfg;
            end
        endcase
    end

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        if (ctr_exists(IDX_W'(i), HPM_MASK)) begin : g_live
            logic [XW-1:0] cnt_q;
            logic [XW-1:0] cfg_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                    cfg_q <= '0;
                end else begin
                    if (cnt_we && idx == IDX_W'(i)) cnt_q <= nxt_cnt;
                    if (cfg_we && idx == IDX_W'(i)) cfg_q <= nxt_cfg;
                end
            end
            assign cnt_v[i] = cnt_q;
            assign cfg_v[i] = cfg_q;
        end else begin : g_absent
            assign cnt_v[i] = '0;
            assign cfg_v[i] = '0;
        end
    end
endmodule

// File: rtl/dlg_ctr_access.sv
module dlg_ctr_access
    import dca_pkg::*;
#(
    parameter logic [NCTR-1:0] HPM_MASK = 32'h8000_00F8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        prv,
    input  logic              virt_on,
    input  logic              guest_sel,
    input  logic [SEL_W-1:0]  sel,
    input  logic [2:0]        alias_num,
    input  logic [XW-1:0]     wdata,
    input  logic              xlen64,
    input  logic              dlg_en,
    input  logic [NCTR-1:0]   ctr_en,
    input  logic              gate_open,
    input  logic [NFEAT-1:0]  feat,
    output logic              rsp_valid,
    output logic [XW-1:0]     rsp_rdata,
    output logic              rsp_ill,
    output logic              rsp_virt
);
    dec_t          dec;
    logic [XW-1:0] bank_rd;
    logic          r_gate;
    alias_e        r_kind;
    logic          r_wide;

    dca_decode #(.HPM_MASK(HPM_MASK)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .prv       (prv),
        .virt_on   (virt_on),
        .guest_sel (guest_sel),
        .sel       (sel),
        .alias_num (alias_num),
        .xlen64    (xlen64),
        .dlg_en    (dlg_en),
        .ctr_en    (ctr_en),
        .gate_open (gate_open),
        .feat      (feat),
        .dec       (dec)
    );

    dca_bank #(.HPM_MASK(HPM_MASK)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (dec.legal),
        .wr_en   (dec.legal && req_write),
        .idx     (dec.idx),
        .kind    (dec.kind),
        .wide    (dec.wide),
        .wdata   (wdata),
        .rd_data (bank_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_ill   <= 1'b0;
            rsp_virt  <= 1'b0;
            r_gate    <= 1'b0;
            r_kind    <= AL_NONE;
            r_wide    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= bank_rd;
            rsp_ill   <= dec.ill;
            rsp_virt  <= dec.virt;
            r_gate    <= gate_open;
            r_kind    <= dec.kind;
            r_wide    <= dec.wide;
        end
    end

    // R11: a refused access returns zero data
    p_exc_zero_data_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_ill || rsp_virt)) |-> (rsp_rdata == '0));

    // R7: hidden bit never visible in the full-width configuration view
    p_hidden_bit_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && r_kind == AL_CFG && r_wide) |-> !rsp_rdata[HIDE_BIT]);

    // R10: a closed gate always yields illegal instruction
    p_gate_first_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !r_gate) |-> (rsp_ill && !rsp_virt));
endmodule

// File: tb/test_dlg_ctr_access.sv
module test_dlg_ctr_access;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HPMM = 32'h8000_00F8;

    typedef struct {
        logic [63:0] rd;
        logic        ill;
        logic        vi;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  prv = 2'd3;
    logic        virt_on = 1'b0;
    logic        guest_sel = 1'b0;
    logic [8:0]  sel = '0;
    logic [2:0]  alias_num = '0;
    logic [63:0] wdata = '0;
    logic        xlen64 = 1'b1;
    logic        dlg_en = 1'b1;
    logic [31:0] ctr_en = '1;
    logic        gate_open = 1'b1;
    logic [3:0]  feat = 4'hF;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_ill;
    logic        rsp_virt;

    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    exp_t q[$];
    logic [63:0] m_cnt [32];
    logic [63:0] m_cfg [32];

    localparam logic [63:0] B62 = 64'h4000_0000_0000_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlg_ctr_access #(.HPM_MASK(HPMM)) i_dlg_ctr_access (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .prv(prv), .virt_on(virt_on), .guest_sel(guest_sel), .sel(sel),
        .alias_num(alias_num), .wdata(wdata), .xlen64(xlen64), .dlg_en(dlg_en),
        .ctr_en(ctr_en), .gate_open(gate_open), .feat(feat),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ill(rsp_ill),
        .rsp_virt(rsp_virt)
    );

    // monitor: pop and compare each response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R12 unexpected response rdata=%h", rsp_rdata);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_rdata !== e.rd || rsp_ill !== e.ill || rsp_virt !== e.vi) begin
                    failures++;
                    $display("FAIL %s rdata=%h exp=%h ill=%b exp=%b virt=%b exp=%b",
                             e.tag, rsp_rdata, e.rd, rsp_ill, e.ill, rsp_virt, e.vi);
                end
            end
        end
    end

    // driver: compute expectation from the requirements, then drive
    task automatic acc(input logic [8:0] s, input logic [2:0] a, input bit w,
                       input logic [63:0] d, input string tag);
        exp_t e;
        bit inr, legal, f;
        int i;
        e.ill = 0; e.vi = 0; e.rd = '0; e.tag = tag; legal = 0;
        inr = (s >= 9'h40) && (s <= 9'h5F);
        i = int'(s) - 64;
        if (!gate_open) e.ill = 1;
        else if (!inr) legal = 0;
        else if (virt_on) begin
            if (prv == 2'd1 && !dlg_en) e.ill = 1; else e.vi = 1;
        end
        else if (prv == 2'd0) e.ill = 1;
        else if (guest_sel) e.ill = 1;
        else if (!dlg_en) e.ill = 1;
        else if (a == 0 || a == 3 || a == 6 || a == 7) e.ill = 1;
        else if (xlen64 && (a == 4 || a == 5)) e.ill = 1;
        else if (i == 1) e.ill = 1;
        else if (!ctr_en[i]) e.ill = 1;
        else begin
            if (i == 0 || i == 2) f = (a == 1 || a == 4) ? feat[0] : feat[3];
            else f = feat[1] && HPMM[i] && (a != 5 || feat[2]);
            if (!f) e.ill = 1; else legal = 1;
        end
        if (legal) begin
            case (a)
                3'd1: e.rd = xlen64 ? m_cnt[i] : {32'h0, m_cnt[i][31:0]};
                3'd4: e.rd = {32'h0, m_cnt[i][63:32]};
                3'd2: e.rd = xlen64 ? (m_cfg[i] & ~B62) : {32'h0, m_cfg[i][31:0]};
                default: e.rd = {32'h0, m_cfg[i][63:32] & 32'hBFFF_FFFF};
            endcase
            if (w) begin
                case (a)
                    3'd1: if (xlen64) m_cnt[i] = d; else m_cnt[i][31:0] = d[31:0];
                    3'd4: m_cnt[i][63:32] = d[31:0];
                    3'd2: if (xlen64) m_cfg[i] = (d & ~B62) | (m_cfg[i] & B62);
                          else m_cfg[i][31:0] = d[31:0];
                    default: begin
                        m_cfg[i][61:32] = d[29:0];
                        m_cfg[i][63] = d[31];
                    end
                endcase
            end
        end
        @(negedge clk);
        req_valid = 1; req_write = w; sel = s; alias_num = a; wdata = d;
        q.push_back(e);
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            m_cnt[k] = '0;
            m_cfg[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R12: reset state
        checks++;
        if (rsp_valid !== 1'b0 || rsp_rdata !== 64'h0) begin
            failures++;
            $display("FAIL R12 reset valid=%b rdata=%h exp=0/0", rsp_valid, rsp_rdata);
        end
        // R2: 64-bit counter write then read (write returns old value)
        acc(9'h43, 3'd1, 1, 64'h1234_5678_9ABC_DEF0, "R2 wide cnt write");
        acc(9'h43, 3'd1, 0, 0, "R2 wide cnt read");
        // R2: 32-bit halves
        xlen64 = 0;
        acc(9'h40, 3'd1, 1, 64'hFFFF_FFFF_AAAA_0001, "R2 low half write");
        acc(9'h40, 3'd4, 1, 64'h0000_0000_5555_0002, "R2 high half write");
        acc(9'h40, 3'd1, 0, 0, "R2 low half read");
        xlen64 = 1;
        acc(9'h40, 3'd1, 0, 0, "R2 full read of halves");
        // R7: hidden bit
        acc(9'h42, 3'd2, 1, '1, "R7 cfg all-ones write");
        acc(9'h42, 3'd2, 0, 0, "R7 cfg read hides bit 62");
        xlen64 = 0;
        acc(9'h44, 3'd5, 1, 64'hFFFF_FFFF, "R7 cfg high write");
        acc(9'h44, 3'd5, 0, 0, "R7 cfg high read hides bit 30");
        xlen64 = 1;
        acc(9'h44, 3'd2, 0, 0, "R7 cfg wide read");
        // R3 and R11: delegation off, counter disabled, no state change
        dlg_en = 0;
        acc(9'h43, 3'd1, 1, 64'hDEAD, "R3 dlg off write");
        dlg_en = 1;
        ctr_en[3] = 0;
        acc(9'h43, 3'd1, 1, 64'hBEEF, "R3 ctr disabled write");
        ctr_en[3] = 1;
        acc(9'h43, 3'd1, 0, 0, "R11 refused writes left value");
        // R4: bad aliases and width
        acc(9'h43, 3'd3, 0, 0, "R4 alias 3");
        acc(9'h43, 3'd6, 1, 64'h1, "R4 alias 6");
        acc(9'h43, 3'd0, 0, 0, "R4 alias 0");
        acc(9'h43, 3'd7, 0, 0, "R4 alias 7");
        acc(9'h43, 3'd4, 0, 0, "R4 alias 4 in xlen64");
        acc(9'h43, 3'd5, 1, 64'h1, "R4 alias 5 in xlen64");
        // R5: timer slot
        acc(9'h41, 3'd1, 0, 0, "R5 timer alias 1");
        acc(9'h41, 3'd2, 1, 64'h7, "R5 timer alias 2");
        // R6: feature and existence
        acc(9'h49, 3'd1, 1, 64'h9, "R6 absent counter 9");
        feat[1] = 0;
        acc(9'h43, 3'd1, 0, 0, "R6 no hpm");
        feat[1] = 1; feat[2] = 0; xlen64 = 0;
        acc(9'h43, 3'd5, 0, 0, "R6 no ovf filter alias 5");
        acc(9'h43, 3'd2, 1, 64'h55, "R6 alias 2 ok without filter");
        feat[2] = 1; xlen64 = 1; feat[3] = 0;
        acc(9'h40, 3'd2, 0, 0, "R6 no cfg on counter 0");
        acc(9'h43, 3'd2, 0, 0, "R6 hpm cfg unaffected by cfg flag");
        feat[3] = 1; feat[0] = 0;
        acc(9'h42, 3'd1, 0, 0, "R6 no base counter");
        feat[0] = 1;
        // R8: virtualization
        virt_on = 1; prv = 2'd1;
        acc(9'h43, 3'd1, 1, 64'h3, "R8 VS dlg on");
        dlg_en = 0;
        acc(9'h43, 3'd1, 0, 0, "R8 VS dlg off");
        dlg_en = 1; prv = 2'd0;
        acc(9'h43, 3'd1, 0, 0, "R8 VU");
        virt_on = 0;
        acc(9'h43, 3'd1, 0, 0, "R8 U");
        // R9: guest select set from M/S
        prv = 2'd1; guest_sel = 1;
        acc(9'h43, 3'd1, 1, 64'h4, "R9 guest from S");
        prv = 2'd3;
        acc(9'h42, 3'd2, 0, 0, "R9 guest from M");
        guest_sel = 0;
        // R10: gate first
        gate_open = 0; virt_on = 1; prv = 2'd1;
        acc(9'h43, 3'd1, 1, 64'h5, "R10 gate closed VS");
        virt_on = 0; prv = 2'd3;
        acc(9'h30, 3'd1, 0, 0, "R10 gate closed out of range");
        gate_open = 1;
        // R1: range edges
        acc(9'h30, 3'd1, 0, 0, "R1 below range");
        acc(9'h60, 3'd1, 1, 64'hF, "R1 above range write");
        acc(9'h5F, 3'd1, 1, 64'hCAFE_F00D, "R1 top counter write");
        acc(9'h5F, 3'd1, 0, 0, "R1 top counter read");
        acc(9'h43, 3'd1, 0, 0, "R1 counter 3 still intact");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R12 missing responses=%0d exp=0", q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule